// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Change Wake-Up

This block is one 8-bit general-purpose I/O port for a small microcontroller. Software reaches it through a three-register window on a simple register bus. The three registers are a pin data latch, a per-pin direction register and a per-pin wake-up enable. Each pin drives a tri-state pad through separate out, output-enable and pull-up signals. A pin is an output when its direction bit is 0 and an input when the bit is 1. For input pins, a read returns the synchronized pad level. For output pins, a read returns what was written.

Three pins can carry an alternate output in place of the latch: a tone output on bit 3 and two PWM outputs on bits 0 and 1. Static configuration bits select these alternate outputs, and one static bit enables the weak pull-ups for the whole port. An alternate output reaches the pad only while its pin is an output. A pull-up is active only while its pin is an input.

The block also holds the core's halt state. A halt request puts the core to sleep. While the core is asleep, a high-to-low transition on any pin whose wake-up bit is set produces a one-cycle wake pulse and releases the core.

Top module: `gpio_port_wake`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the data latch and wake-up enables read 0, `pad_oe` is 0 and `halted` is 0.
- R2: Writing offset 1 sets the direction bits from the next cycle on. A bit of 0 drives `pad_oe` high for that pin, and a bit of 1 releases it.
- R3: Writing offset 0 loads the latch from the next cycle on. The latch holds its value until offset 0 is written again. A pin without an active alternate function drives the latch bit on `pad_out`.
- R4: A read is combinational. Offset 0 returns the latch bit for output pins and the pad level after a two-flop synchronizer for input pins. Offset 1 returns the direction bits, offset 2 returns the wake-up enables, and offset 3 returns 0.
- R5: `pad_pu` for a pin is 1 exactly when `cfg_pullup_en` is 1 and the pin is an input.
- R6: With `cfg_tone_en` set and bit 3 configured as an output, `pad_out[3]` follows `tone_in`. Otherwise bit 3 drives its latch bit.
- R7: With `cfg_pwm_en[i]` set and bit i (i = 0 or 1) configured as an output, `pad_out[i]` follows `pwm_in[i]`. Otherwise the pin drives its latch bit.
- R8: When `halt_req` is high and the core is not halted, `halted` rises at the next clock. It then stays high until a wake event.
- R9: Consider the core halted and a pad with its wake-up enable bit set that goes from 1 to 0 before clock edge k. Then `wake` is high for exactly one cycle, between edges k+1 and k+2, and `halted` falls at edge k+2.
- R10: A falling edge on a pin whose wake-up bit is clear, or any falling edge while the core is not halted, produces no `wake`.
- R11: If `halt_req` arrives in the same cycle that an enabled falling edge is detected while the core is running, the halt takes effect and no wake occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Weak pull-up enables |
| tone_in | input | 1 | Alternate tone output for bit 3 |
| pwm_in | input | 2 | Alternate PWM outputs for bits 0 and 1 |
| cfg_pullup_en | input | 1 | Static pull-up option |
| cfg_tone_en | input | 1 | Static tone option |
| cfg_pwm_en | input | 2 | Static PWM options |
| halt_req | input | 1 | Request to enter halt |
| halted | output | 1 | Core is halted |
| wake | output | 1 | One-cycle wake pulse |

## Verification
A halt request can land in the same cycle that the synchronizer reports an enabled falling edge. Halt entry and wake detection then collide. The bench provokes this by dropping a pad and asserting `halt_req` exactly two clocks later. The reference model then expects `halted` to rise with no wake pulse. A later enabled edge must still release the core. The same per-cycle model also judges bus writes and pad changes that coincide with alternate-output and pull-up gating.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_WKEN = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_sync,
  output logic [W-1:0] fall_vec
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pad_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign pad_sync = stage2_q;
  assign fall_vec = prev_q & ~stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] wken_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  // input pins show the pad, output pins show the latch
  function automatic logic [W-1:0] port_view(input logic [W-1:0] dir,
                                             input logic [W-1:0] latch,
                                             input logic [W-1:0] pad);
    return (dir & pad) | (~dir & latch);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      wken_q <= '0;
    end else if (bus_we) begin
      case (sel)
        REG_DATA: data_q <= bus_wdata;
        REG_DIR:  dir_q  <= bus_wdata;
        REG_WKEN: wken_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_DATA: bus_rdata = port_view(dir_q, data_q, pad_sync);
      REG_DIR:  bus_rdata = dir_q;
      REG_WKEN: bus_rdata = wken_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W        = 8,
  parameter int TONE_BIT = 3,
  parameter int PWM0_BIT = 0,
  parameter int PWM1_BIT = 1
) (
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic         tone_in,
  input  logic [1:0]   pwm_in,
  input  logic         cfg_pullup_en,
  input  logic         cfg_tone_en,
  input  logic [1:0]   cfg_pwm_en,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  logic [W-1:0] alt_sel;
  logic [W-1:0] alt_val;

  always_comb begin
    alt_sel = '0;
    alt_val = '0;
    alt_sel[TONE_BIT] = cfg_tone_en;
    alt_val[TONE_BIT] = tone_in;
    alt_sel[PWM0_BIT] = cfg_pwm_en[0];
    alt_val[PWM0_BIT] = pwm_in[0];
    alt_sel[PWM1_BIT] = cfg_pwm_en[1];
    alt_val[PWM1_BIT] = pwm_in[1];
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drive_alt;
    assign drive_alt  = alt_sel[i] & ~dir_q[i];
    assign pad_out[i] = drive_alt ? alt_val[i] : data_q[i];
    assign pad_oe[i]  = ~dir_q[i];
    assign pad_pu[i]  = dir_q[i] & cfg_pullup_en;
  end
endmodule

// File: rtl/gpio_port_wake.sv
module gpio_port_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  input  logic         tone_in,
  input  logic [1:0]   pwm_in,
  input  logic         cfg_pullup_en,
  input  logic         cfg_tone_en,
  input  logic [1:0]   cfg_pwm_en,
  input  logic         halt_req,
  output logic         halted,
  output logic         wake
);
  logic [W-1:0] pad_sync;
  logic [W-1:0] fall_vec;
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] wken_q;
  logic [W-1:0] wake_hit;
  logic         halted_q;

  gpio_edge_sync #(.W(W)) i_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .pad_sync(pad_sync), .fall_vec(fall_vec)
  );

  gpio_regs #(.W(W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pad_sync(pad_sync), .bus_rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q), .wken_q(wken_q)
  );

  gpio_pin_mux #(.W(W)) i_mux (
    .data_q(data_q), .dir_q(dir_q), .tone_in(tone_in), .pwm_in(pwm_in),
    .cfg_pullup_en(cfg_pullup_en), .cfg_tone_en(cfg_tone_en),
    .cfg_pwm_en(cfg_pwm_en), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu)
  );

  assign wake_hit = fall_vec & wken_q;
  assign wake     = halted_q & (|wake_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted_q <= 1'b0;
    else if (wake)     halted_q <= 1'b0;
    else if (halt_req) halted_q <= 1'b1;
  end

  assign halted = halted_q;
endmodule

// File: rtl/gpio_port_wake_chk.sv
module gpio_port_wake_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] data_q,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic         halt_req,
  input logic         halted,
  input logic         wake
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1) |=> (pad_oe == ~$past(bus_wdata))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 2'd0) |=> $stable(data_q)); // R3
  AST_READ_OUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (((bus_rdata ^ data_q) & pad_oe) == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R4
  AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0)); // R5
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !halted) |=> halted); // R8
  AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!halted && !wake)); // R9
  AST_WAKE_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> halted); // R10
endmodule

bind gpio_port_wake gpio_port_wake_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_q(data_q),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .halt_req(halt_req),
  .halted(halted), .wake(wake)
);

// File: tb/test_gpio_port_wake.sv
`timescale 1ns/1ps
module test_gpio_port_wake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       tone_in = 1'b0;
  logic [1:0] pwm_in = '0;
  logic       cfg_pullup_en = 1'b0;
  logic       cfg_tone_en = 1'b0;
  logic [1:0] cfg_pwm_en = '0;
  logic       halt_req = 1'b0;
  logic       halted, wake;

  int checks = 0;
  int failures = 0;
  int wake_seen = 0;

  // behavioural reference state
  logic [7:0] m_data, m_dir, m_wk;
  logic       m_halt;
  logic [7:0] hist[$];

  always #2.5 clk = ~clk;

  gpio_port_wake i_gpio_port_wake (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .tone_in(tone_in),
    .pwm_in(pwm_in), .cfg_pullup_en(cfg_pullup_en), .cfg_tone_en(cfg_tone_en),
    .cfg_pwm_en(cfg_pwm_en), .halt_req(halt_req), .halted(halted), .wake(wake)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_data = 8'h00; m_dir = 8'hFF; m_wk = 8'h00; m_halt = 1'b0;
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back(8'h00);
  endtask

  function automatic logic [7:0] exp_rdata();
    case (bus_addr)
      2'd0: return (m_dir & hist[1]) | (~m_dir & m_data);
      2'd1: return m_dir;
      2'd2: return m_wk;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_wake();
    return m_halt && ((hist[2] & ~hist[1] & m_wk) != 8'h00);
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] v;
    v = m_data;
    if (cfg_tone_en && !m_dir[3]) v[3] = tone_in;
    if (cfg_pwm_en[0] && !m_dir[0]) v[0] = pwm_in[0];
    if (cfg_pwm_en[1] && !m_dir[1]) v[1] = pwm_in[1];
    return v;
  endfunction

  // compare, clock once, advance the model, return at the falling edge
  task automatic cycle();
    logic w;
    #1;
    w = exp_wake();
    chk("R4 rdata", bus_rdata, exp_rdata());
    chk("R2 pad_oe", pad_oe, ~m_dir);
    chk("R5 pad_pu", pad_pu, cfg_pullup_en ? m_dir : 8'h00);
    chk("R3 R6 R7 pad_out", pad_out, exp_out());
    chk("R8 R11 halted", {7'd0, halted}, {7'd0, m_halt});
    chk("R9 R10 wake", {7'd0, wake}, {7'd0, w});
    if (wake) wake_seen++;
    @(posedge clk);
    if (bus_we) begin
      if (bus_addr == 2'd0) m_data = bus_wdata;
      if (bus_addr == 2'd1) m_dir = bus_wdata;
      if (bus_addr == 2'd2) m_wk = bus_wdata;
    end
    if (w) m_halt = 1'b0;
    else if (halt_req) m_halt = 1'b1;
    hist.push_front(pad_in);
    void'(hist.pop_back());
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    cycle();
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_addr = 2'd1; #1;
    chk("R1 dir reset", bus_rdata, 8'hFF);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 halted reset", {7'd0, halted}, 8'h00);
    bus_addr = 2'd2; #1; chk("R1 wken reset", bus_rdata, 8'h00);
    @(negedge clk);

    // R2 R3 R4: low nibble output, high nibble input
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hA5);
    bus_addr = 2'd0;
    pad_in = 8'h3C; idle(3);
    pad_in = 8'hC3; idle(3);
    chk("R3 latch held", pad_out, 8'hA5);
    bus_addr = 2'd3; idle(1);
    bus_addr = 2'd2; idle(1);
    wr(2'd1, 8'h0F); bus_addr = 2'd0; idle(3);

    // R5 pull-ups
    cfg_pullup_en = 1'b1; idle(2);
    wr(2'd1, 8'h5A); idle(1);
    cfg_pullup_en = 1'b0; idle(1);

    // R6 R7 alternate outputs
    cfg_tone_en = 1'b1; cfg_pwm_en = 2'b11;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hF4);
    tone_in = 1'b1; pwm_in = 2'b10; idle(1);
    chk("R6 tone out", {7'd0, pad_out[3]}, 8'h01);
    tone_in = 1'b0; pwm_in = 2'b01; idle(1);
    chk("R7 pwm out", {6'd0, pad_out[1:0]}, 8'h01);
    wr(2'd1, 8'hFF); tone_in = 1'b1; pwm_in = 2'b11; idle(2);
    cfg_tone_en = 1'b0; cfg_pwm_en = 2'b00;

    // R10 falling edge while running gives no wake
    wr(2'd2, 8'h81);
    pad_in = 8'hFF; idle(4);
    pad_in = 8'hFE; idle(4);
    chk("R10 no wake running", wake_seen[7:0], 8'h00);

    // R8 R9 R10 halt and wake
    pad_in = 8'hFF; idle(4);
    halt_req = 1'b1; idle(1); halt_req = 1'b0;
    chk("R8 halted set", {7'd0, halted}, 8'h01);
    pad_in = 8'hFD; idle(5);
    chk("R10 disabled pin", wake_seen[7:0], 8'h00);
    pad_in = 8'h7D; idle(5);
    chk("R9 one wake", wake_seen[7:0], 8'h01);
    chk("R9 released", {7'd0, halted}, 8'h00);

    // R11 halt request coincides with detected enabled edge
    pad_in = 8'hFF; idle(4);
    pad_in = 8'hFE; idle(2);
    halt_req = 1'b1; idle(1); halt_req = 1'b0;
    idle(2);
    chk("R11 halt wins", {7'd0, halted}, 8'h01);
    chk("R11 no wake", wake_seen[7:0], 8'h01);
    pad_in = 8'hFF; idle(4);
    pad_in = 8'h7F; idle(5);
    chk("R9 second wake", wake_seen[7:0], 8'h02);

    finish_run();
  end
endmodule